// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, while a frame is still arriving, whether the frame is addressed to this station. The destination address bytes arrive one per cycle, first byte first. The block runs a per-byte CRC over them and keeps running match flags. One cycle after the last address byte it gives a single-cycle verdict.

Four rules decide the verdict, and a configuration byte controls them:
- Promiscuous mode accepts every frame.
- An all-ones address is broadcast.
- Any other address with the group bit set is multicast, filtered through a hash table.
- Everything else is unicast and must equal the programmed station address.

A small register port loads and reads back the station address, the hash table and the configuration byte. Frame storage and body CRC checking belong to the neighbouring blocks.

Top module: `daf_addr_filter`

## Requirements
- R1: When configuration bit 4 is set, every completed address is accepted, whatever its class.
- R2: An address whose six bytes are all 0xFF is broadcast. Without promiscuous mode it is accepted exactly when configuration bit 2 is set.
- R3: An address that is not broadcast but has bit 0 of its first byte set is multicast. Without promiscuous mode it is rejected unless configuration bit 3 is set. When bit 3 is set, it is accepted when the hash table bit selected by index k is 1. That bit is bit k%8 of hash byte k/8.
- R3 (index): k is bits 31:26 of a CRC over the six bytes. The CRC is preset to all ones and uses polynomial 0x04C11DB7, shifting left. Each byte is fed LSB first, and there is no final inversion.
- R4: Any other address is unicast. Without promiscuous mode it is accepted only when every byte equals the station byte of the same position; station byte 0 is compared with the first address byte.
- R5: Register map: addresses 0..5 are station bytes 0..5, addresses 6..13 are hash bytes 0..7, and address 14 is the configuration byte. A write takes effect at the clock edge. Reads are combinational and return the stored value. Unmapped addresses read 0.
- R6: acc_valid is high for exactly one cycle, the cycle after the edge that samples the sixth address byte. acc_ok carries the verdict in that cycle and is low otherwise. Further bytes before the next start of frame are ignored.
- R7: A byte presented with rx_sof high is always byte 0 of a new address. This holds even in the middle of an earlier address, which is then abandoned without a verdict.
- R8: After reset all registers read 0 and acc_valid is low. Bytes that arrive before the first start of frame are ignored.
- R9: A register write on the same edge as the sixth address byte does not affect that frame's verdict; the verdict uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register address for both write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| rx_valid | input | 1 | An address byte is present on rx_data |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_data | input | 8 | Address byte |
| acc_valid | output | 1 | Verdict strobe |
| acc_ok | output | 1 | Verdict: frame accepted |

## Verification
A register write and a frame decision can land on the same clock edge. The case that matters is a write to the configuration, station or hash registers on the very edge that samples the sixth address byte. The bench provokes this in directed cases: it flips the promiscuous bit, and it changes a station byte, on that edge. It predicts the verdict from its shadow register copy taken before the write, and then reads the register back to confirm the write itself landed.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam int unsigned BYTE_W          = 8;
   localparam int unsigned CRC_W           = 32;
   localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
   localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;

   // configuration byte bit positions
   localparam int unsigned CFG_BCAST_BIT   = 2;
   localparam int unsigned CFG_MCAST_BIT   = 3;
   localparam int unsigned CFG_PROMISC_BIT = 4;

   typedef enum logic [1:0] {
      CLS_UNICAST   = 2'd0,
      CLS_MULTICAST = 2'd1,
      CLS_BROADCAST = 2'd2
   } addr_class_e;
endpackage

// File: rtl/daf_crc_byte.sv
module daf_crc_byte #(
   parameter int unsigned             CW   = 32,
   parameter int unsigned             DW   = 8,
   parameter logic [CW-1:0]           POLY = 32'h04C1_1DB7
) (
   input  logic [CW-1:0] crc_in,
   input  logic [DW-1:0] data_in,
   output logic [CW-1:0] crc_out
);
   if (CW < 8) begin : g_bad_cw
      $error("daf_crc_byte: CW must be at least 8");
   end

   logic [CW-1:0] stage [DW+1];

   assign stage[0] = crc_in;

   // one shift stage per data bit, least significant data bit first
   for (genvar b = 0; b < DW; b++) begin : g_bit
      logic fb;
      assign fb           = stage[b][CW-1] ^ data_in[b];
      assign stage[b+1]   = {stage[b][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DW];
endmodule

// File: rtl/daf_regfile.sv
module daf_regfile #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned TBL_BYTES  = 8,
   parameter int unsigned REG_AW     = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [REG_AW-1:0]         addr,
   input  logic [7:0]                wdata,
   output logic [7:0]                rdata,
   output logic [ADDR_BYTES*8-1:0]   station_flat,
   output logic [TBL_BYTES*8-1:0]    hash_flat,
   output logic [7:0]                cfg
);
   localparam int unsigned NREGS   = ADDR_BYTES + TBL_BYTES + 1;
   localparam int unsigned CFG_IDX = NREGS - 1;

   if (NREGS > (1 << REG_AW)) begin : g_bad_aw
      $error("daf_regfile: REG_AW too narrow for the register map");
   end

   logic [7:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
         end else if (we && (addr == REG_AW'(i))) begin
            regs[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (addr == REG_AW'(i)) rdata = regs[i];
      end
   end

   for (genvar s = 0; s < ADDR_BYTES; s++) begin : g_station
      assign station_flat[s*8 +: 8] = regs[s];
   end

   for (genvar h = 0; h < TBL_BYTES; h++) begin : g_hash
      assign hash_flat[h*8 +: 8] = regs[ADDR_BYTES + h];
   end

   assign cfg = regs[CFG_IDX];
endmodule

// File: rtl/daf_frame_tracker.sv
module daf_frame_tracker
   import daf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned HASH_BITS  = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rx_valid,
   input  logic                      rx_sof,
   input  logic [7:0]                rx_data,
   input  logic [ADDR_BYTES*8-1:0]   station_flat,
   output logic                      last_byte,
   output addr_class_e               cls,
   output logic                      uc_hit,
   output logic [HASH_BITS-1:0]      hash_idx
);
   localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CRC_W-1:0] crc_q;
   logic             uc_q, bc_q, mc_q;

   logic             take;
   logic [CNT_W-1:0] idx;
   logic [CRC_W-1:0] crc_base, crc_next;
   logic             uc_next, bc_next, mc_next;
   logic [7:0]       station_sel;

   // a new start always wins; otherwise only bytes before the last count
   assign take     = rx_valid && (rx_sof || (cnt_q < CNT_DONE));
   assign idx      = rx_sof ? '0 : cnt_q;
   assign crc_base = rx_sof ? CRC_PRESET : crc_q;

   always_comb begin
      station_sel = '0;
      for (int i = 0; i < ADDR_BYTES; i++) begin
         if (idx == CNT_W'(i)) station_sel = station_flat[i*8 +: 8];
      end
   end

   daf_crc_byte #(
      .CW   (CRC_W),
      .DW   (BYTE_W),
      .POLY (CRC_POLY)
   ) u_crc (
      .crc_in  (crc_base),
      .data_in (rx_data),
      .crc_out (crc_next)
   );

   assign uc_next = (rx_sof ? 1'b1 : uc_q) && (rx_data == station_sel);
   assign bc_next = (rx_sof ? 1'b1 : bc_q) && (&rx_data);
   assign mc_next = (idx == '0) ? rx_data[0] : mc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_DONE;
         crc_q <= CRC_PRESET;
         uc_q  <= 1'b0;
         bc_q  <= 1'b0;
         mc_q  <= 1'b0;
      end else if (take) begin
         cnt_q <= idx + 1'b1;
         crc_q <= crc_next;
         uc_q  <= uc_next;
         bc_q  <= bc_next;
         mc_q  <= mc_next;
      end
   end

   assign last_byte = take && (idx == CNT_LAST);
   assign uc_hit    = uc_next;
   assign hash_idx  = crc_next[CRC_W-1 -: HASH_BITS];

   always_comb begin
      if (bc_next)      cls = CLS_BROADCAST;
      else if (mc_next) cls = CLS_MULTICAST;
      else              cls = CLS_UNICAST;
   end
endmodule

// File: rtl/daf_addr_filter.sv
module daf_addr_filter
   import daf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned HASH_BITS  = 6,
   parameter int unsigned REG_AW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_data,
   output logic              acc_valid,
   output logic              acc_ok
);
   localparam int unsigned TBL_BITS  = 1 << HASH_BITS;
   localparam int unsigned TBL_BYTES = TBL_BITS / 8;

   if (HASH_BITS < 3 || HASH_BITS > 10) begin : g_bad_hash
      $error("daf_addr_filter: HASH_BITS must be 3..10");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 16) begin : g_bad_len
      $error("daf_addr_filter: ADDR_BYTES must be 1..16");
   end

   logic [ADDR_BYTES*8-1:0] station_w;
   logic [TBL_BITS-1:0]     hash_w;
   logic [7:0]              cfg_w;
   logic                    last_w;
   addr_class_e             cls_w;
   logic                    uc_hit_w;
   logic [HASH_BITS-1:0]    hidx_w;
   logic                    verdict;
   logic                    valid_q, ok_q;

   daf_regfile #(
      .ADDR_BYTES (ADDR_BYTES),
      .TBL_BYTES  (TBL_BYTES),
      .REG_AW     (REG_AW)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (cfg_we),
      .addr         (cfg_addr),
      .wdata        (cfg_wdata),
      .rdata        (cfg_rdata),
      .station_flat (station_w),
      .hash_flat    (hash_w),
      .cfg          (cfg_w)
   );

   daf_frame_tracker #(
      .ADDR_BYTES (ADDR_BYTES),
      .HASH_BITS  (HASH_BITS)
   ) u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_sof       (rx_sof),
      .rx_data      (rx_data),
      .station_flat (station_w),
      .last_byte    (last_w),
      .cls          (cls_w),
      .uc_hit       (uc_hit_w),
      .hash_idx     (hidx_w)
   );

   // rule priority: promiscuous, then class-specific gate
   always_comb begin
      if (cfg_w[CFG_PROMISC_BIT]) begin
         verdict = 1'b1;
      end else begin
         unique case (cls_w)
            CLS_BROADCAST: verdict = cfg_w[CFG_BCAST_BIT];
            CLS_MULTICAST: verdict = cfg_w[CFG_MCAST_BIT] && hash_w[hidx_w];
            default:       verdict = uc_hit_w;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ok_q    <= 1'b0;
      end else begin
         valid_q <= last_w;
         ok_q    <= last_w && verdict;
      end
   end

   assign acc_valid = valid_q;
   assign acc_ok    = ok_q;
endmodule

// File: rtl/daf_addr_filter_chk.sv
module daf_addr_filter_chk
   import daf_pkg::*;
#(
   parameter int unsigned REG_AW = 4,
   parameter int unsigned NREGS  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_AW-1:0] cfg_addr,
   input logic [7:0]        cfg_wdata,
   input logic [7:0]        cfg_rdata,
   input logic              rx_valid,
   input logic              acc_valid,
   input logic              acc_ok,
   input logic [7:0]        cfg_w,
   input addr_class_e       cls_w,
   input logic              uc_hit_w
);
   logic promisc, bcast_en, mcast_en, mapped;
   assign promisc  = cfg_w[CFG_PROMISC_BIT];
   assign bcast_en = cfg_w[CFG_BCAST_BIT];
   assign mcast_en = cfg_w[CFG_MCAST_BIT];
   assign mapped   = (32'(cfg_addr) < NREGS);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> !acc_valid);

   a_r6_ok_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_ok);

   a_r6_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> $past(rx_valid));

   a_r1_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(promisc)) |-> acc_ok);

   a_r2_bcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(!promisc && cls_w == CLS_BROADCAST)) |-> (acc_ok == $past(bcast_en)));

   a_r3_mcast_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(!promisc && cls_w == CLS_MULTICAST && !mcast_en)) |-> !acc_ok);

   a_r4_unicast_match: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && $past(!promisc && cls_w == CLS_UNICAST)) |-> (acc_ok == $past(uc_hit_w)));

   a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_we) && $past(mapped) && (cfg_addr == $past(cfg_addr)))
      |-> (cfg_rdata == $past(cfg_wdata)));

   always_comb begin
      if (rst_n && !mapped) begin
         a_r5_unmapped_zero: assert (cfg_rdata == 8'h00);
      end
   end
endmodule

bind daf_addr_filter daf_addr_filter_chk #(
   .REG_AW (REG_AW),
   .NREGS  (ADDR_BYTES + (1 << HASH_BITS) / 8 + 1)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .rx_valid  (rx_valid),
   .acc_valid (acc_valid),
   .acc_ok    (acc_ok),
   .cfg_w     (cfg_w),
   .cls_w     (cls_w),
   .uc_hit_w  (uc_hit_w)
);

// File: tb/daf_addr_filter_tb.sv
module daf_addr_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CFG_ADR    = 14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       rx_valid = 1'b0;
   logic       rx_sof = 1'b0;
   logic [7:0] rx_data = '0;
   logic       acc_valid, acc_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] sh_sta [6];
   logic [7:0] sh_hash [8];
   logic [7:0] sh_cfg;

   always #(CLK_PERIOD/2) clk = ~clk;

   daf_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
      .acc_valid(acc_valid), .acc_ok(acc_ok)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [5:0] bench_hidx(input logic [7:0] a [6]);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic top = c[31] ^ a[i][b];
            c = c << 1;
            if (top) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c[31:26];
   endfunction

   function automatic bit bench_expect(input logic [7:0] a [6]);
      bit allff = 1'b1;
      bit same = 1'b1;
      logic [5:0] k;
      for (int i = 0; i < 6; i++) begin
         if (a[i] != 8'hFF) allff = 1'b0;
         if (a[i] != sh_sta[i]) same = 1'b0;
      end
      if (sh_cfg[4]) return 1'b1;
      if (allff) return sh_cfg[2];
      if (a[0][0]) begin
         if (!sh_cfg[3]) return 1'b0;
         k = bench_hidx(a);
         return sh_hash[k[5:3]][k[2:0]];
      end
      return same;
   endfunction

   task automatic write_reg(input int adr, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(adr); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (adr < 6) sh_sta[adr] = d;
      else if (adr < 14) sh_hash[adr-6] = d;
      else if (adr == 14) sh_cfg = d;
   endtask

   task automatic read_check(input int adr, input logic [7:0] exp, input string req);
      @(negedge clk);
      cfg_addr = 4'(adr);
      #1;
      check(cfg_rdata == exp, req, cfg_rdata, exp);
   endtask

   // send six address bytes plus 'extra' trailing bytes; optional write on the sixth byte
   task automatic send_frame(input logic [7:0] a [6], input int extra, input bit exp_ok,
                             input bit wr, input int wa, input logic [7:0] wd, input string req);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i > 0) check(acc_valid == 1'b0, "R6 early", acc_valid, 0);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_data = a[i];
         if (i == 5 && wr) begin
            cfg_we = 1'b1; cfg_addr = 4'(wa); cfg_wdata = wd;
         end
      end
      @(negedge clk);
      cfg_we = 1'b0; rx_sof = 1'b0;
      check(acc_valid == 1'b1, {req, " valid"}, acc_valid, 1);
      check(acc_ok == exp_ok, req, acc_ok, exp_ok);
      if (extra > 0) begin rx_valid = 1'b1; rx_data = 8'($urandom); end
      else rx_valid = 1'b0;
      for (int k = 1; k <= extra + 1; k++) begin
         @(negedge clk);
         check(acc_valid == 1'b0 && acc_ok == 1'b0, "R6 single pulse / extras ignored", acc_valid, 0);
         if (k < extra) rx_data = 8'($urandom);
         else rx_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] a [6];
      logic [5:0] k;
      bit e;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 6; i++) sh_sta[i] = '0;
      for (int i = 0; i < 8; i++) sh_hash[i] = '0;
      sh_cfg = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state and pre-start bytes ignored
      check(acc_valid == 1'b0, "R8 acc_valid at reset", acc_valid, 0);
      for (int r = 0; r < 16; r++) read_check(r, 8'h00, "R8 register reset");
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hFF;
         check(acc_valid == 1'b0, "R8 bytes before start ignored", acc_valid, 0);
      end
      @(negedge clk); rx_valid = 1'b0;
      check(acc_valid == 1'b0, "R8 bytes before start ignored", acc_valid, 0);

      // R5: register readback, unmapped address
      for (int r = 0; r < 15; r++) begin
         logic [7:0] v = 8'($urandom);
         write_reg(r, v);
         read_check(r, v, "R5 readback");
      end
      read_check(15, 8'h00, "R5 unmapped");

      // program a station address
      a = '{8'h02, 8'h1A, 8'hC3, 8'h44, 8'h95, 8'h6E};
      for (int i = 0; i < 6; i++) write_reg(i, a[i]);
      for (int i = 0; i < 8; i++) write_reg(6 + i, 8'h00);
      write_reg(CFG_ADR, 8'h00);

      // R4: exact match, one byte off, last byte off
      send_frame(a, 0, 1'b1, 0, 0, 0, "R4 unicast match");
      a[3] = 8'h45;
      send_frame(a, 0, 1'b0, 0, 0, 0, "R4 unicast mismatch mid byte");
      a[3] = 8'h44; a[5] = 8'h6F;
      send_frame(a, 0, 1'b0, 0, 0, 0, "R4 unicast mismatch last byte");
      a[5] = 8'h6E;

      // R2: broadcast gated by bit 2
      begin
         logic [7:0] b [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
         send_frame(b, 0, 1'b0, 0, 0, 0, "R2 broadcast disabled");
         write_reg(CFG_ADR, 8'h04);
         send_frame(b, 0, 1'b1, 0, 0, 0, "R2 broadcast enabled");
         b[5] = 8'hFE;
         write_reg(CFG_ADR, 8'h0C);
         send_frame(b, 0, bench_expect(b), 0, 0, 0, "R3 near-broadcast is multicast");
      end

      // R3: multicast hash hit, miss, disabled
      begin
         logic [7:0] m [6] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB};
         k = bench_hidx(m);
         write_reg(6 + int'(k[5:3]), 8'h01 << k[2:0]);
         write_reg(CFG_ADR, 8'h08);
         send_frame(m, 0, 1'b1, 0, 0, 0, "R3 multicast hash hit");
         write_reg(6 + int'(k[5:3]), ~(8'h01 << k[2:0]));
         send_frame(m, 0, 1'b0, 0, 0, 0, "R3 multicast hash miss");
         write_reg(6 + int'(k[5:3]), 8'hFF);
         write_reg(CFG_ADR, 8'h00);
         send_frame(m, 0, 1'b0, 0, 0, 0, "R3 multicast disabled");
         // R1: promiscuous accepts everything
         write_reg(CFG_ADR, 8'h10);
         send_frame(m, 0, 1'b1, 0, 0, 0, "R1 promiscuous multicast");
      end
      a[0] = 8'h00;
      send_frame(a, 0, 1'b1, 0, 0, 0, "R1 promiscuous foreign unicast");
      a[0] = 8'h02;

      // R6: trailing bytes ignored, single strobe
      write_reg(CFG_ADR, 8'h00);
      send_frame(a, 4, 1'b1, 0, 0, 0, "R6 trailing bytes");

      // R7: abandoned partial frame then restart
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_data = 8'hFF;
      end
      send_frame(a, 0, 1'b1, 0, 0, 0, "R7 restart on start of frame");
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_data = a[i];
      end
      begin
         logic [7:0] b [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
         write_reg(CFG_ADR, 8'h04);
         send_frame(b, 0, 1'b1, 0, 0, 0, "R7 restart discards prior bytes");
      end

      // R9: same-edge write uses prior contents
      write_reg(CFG_ADR, 8'h00);
      a[0] = 8'h04;
      send_frame(a, 0, 1'b0, 1, CFG_ADR, 8'h10, "R9 promisc set on last edge");
      sh_cfg = 8'h10;
      read_check(CFG_ADR, 8'h10, "R9 write landed");
      send_frame(a, 0, 1'b1, 1, CFG_ADR, 8'h00, "R9 promisc cleared on last edge");
      sh_cfg = 8'h00;
      a[0] = 8'h02;
      send_frame(a, 0, 1'b1, 1, 5, 8'h00, "R9 station changed on last edge");
      sh_sta[5] = 8'h00;
      read_check(5, 8'h00, "R9 station write landed");
      send_frame(a, 0, 1'b0, 0, 0, 0, "R4 after station change");

      // random frames
      for (int n = 0; n < 150; n++) begin
         int cls = int'($urandom_range(0, 3));
         if ($urandom_range(0, 3) == 0) write_reg(CFG_ADR, 8'($urandom) & 8'h1C);
         if ($urandom_range(0, 4) == 0) write_reg(6 + int'($urandom_range(0, 7)), 8'($urandom));
         for (int i = 0; i < 6; i++) a[i] = 8'($urandom);
         case (cls)
            0: for (int i = 0; i < 6; i++) a[i] = sh_sta[i];
            1: a[0][0] = 1'b0;
            2: a[0][0] = 1'b1;
            default: for (int i = 0; i < 6; i++) a[i] = 8'hFF;
         endcase
         if (cls == 0 && a[0][0]) a[0][0] = 1'b0;
         e = bench_expect(a);
         send_frame(a, int'($urandom_range(0, 2)), e, 0, 0, 0, "R1/R2/R3/R4 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule